// File: doc/BRIEF.md
# Interrupt Acceptance Window Controller

This block sits between an instruction-issue stage and an interrupt controller and decides, at every instruction boundary, whether a pending interrupt may be taken. Each issued instruction arrives with a one-cycle `issue_valid` strobe and its decode information. That information is the instruction class, the word count, the branch outcome, the number of delay slots, and two hardware-loop fields: a last-iteration flag and the count of loop-body words that remain after the instruction. For the boundary that follows that instruction, the block reports on `allow_o` whether an interrupt may be accepted there. It reports on `irq_take_o` whether the level request `irq_req` is accepted there.

Some instruction classes protect a number of following instructions from interruption. A small run counter and a one-instruction "pending decision" flag track that protection. The flag is needed for short branches, whose protected span depends on the width of the instruction that follows. An interrupt that is held on `irq_req` through a protected run is accepted at the first boundary after the run ends. When a software interrupt at the top priority level is issued, `swi_take_o` pulses on the following cycle to request direct exception entry.

The class codes on `issue_class` are listed in the requirements. Every timing statement assumes that decode values are held stable while `issue_valid` is high. `allow_o` and `irq_take_o` are combinational in the cycle the instruction is issued.

Top module: `iaw_window_ctrl`

## Requirements
- R1: A delayed flow-control instruction (class code 1) with S delay slots on `issue_slots` blocks the boundary after itself and after its first S-1 slot instructions. The boundary after the S-th slot is free. With S=0 nothing is blocked.
- R2: A repeat instruction (class code 2) blocks the boundary after itself only.
- R3: A one-word conditional branch (class code 3) blocks the boundary after itself. If the next issued instruction has `issue_words` greater than 1, the boundary after that instruction is free.
- R4: After a one-word conditional branch (class code 3), a next instruction with `issue_words` equal to 1 also has its following boundary blocked, so two instructions are protected. This holds whether the branch was taken or not.
- R5: A bit-test branch (class code 5) that is not taken (`issue_taken`=0) protects exactly as in R3 and R4.
- R6: A bit-test branch (class code 5) that is taken (`issue_taken`=1) adds no protection, so the boundary after it is free when no other run is active.
- R7: A multi-word conditional branch (class code 4) and a conditional jump (class code 6) each block the boundary after themselves only, whatever the width of the next instruction.
- R8: A top-priority software interrupt (class code 7) makes the boundary after it refuse interrupts and raises `swi_take_o` for exactly the following cycle. It also clears any active protection.
- R9: While `issue_loop_last` is 1, the boundary after an instruction is blocked when `issue_loop_left` is 1, 2 or 3. It is free when that count is 0 or above 3, and free whenever `issue_loop_last` is 0.
- R10: `irq_take_o` is 1 exactly when an instruction is issued, its following boundary is allowed, and `irq_req` is high. A request held through a protected run is therefore taken at the first free boundary.
- R11: A protecting instruction inside an active run sets the remaining span to the larger of the remaining count and its own requirement. The two counts are not added.
- R12: After reset the first issued plain instruction (class code 0) has an allowed boundary, and `swi_take_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | An instruction is issued this cycle |
| issue_class | input | 3 | Instruction class code |
| issue_words | input | WORD_W | Instruction length in program words (1 = one word) |
| issue_taken | input | 1 | Branch outcome of the issued instruction |
| issue_slots | input | SLOT_W | Delay-slot count of a delayed flow-control instruction |
| issue_loop_last | input | 1 | Instruction belongs to the last iteration of a hardware loop |
| issue_loop_left | input | LEFT_W | Loop-body words remaining after this instruction |
| irq_req | input | 1 | Pending interrupt request level |
| allow_o | output | 1 | Boundary after the issued instruction may take an interrupt |
| irq_take_o | output | 1 | Pending interrupt is accepted at this boundary |
| swi_take_o | output | 1 | Forced exception entry after a software interrupt |

## Verification
A run counter that is wrong by one shows at the ports within the run itself. A boundary is either refused one instruction too long or freed one instruction too early, so an interrupt is taken inside a protected run or deferred past its end. A lost or stuck pending-decision flag shows on the instruction right after a short branch, and only when the width of that instruction matters. The directed scenarios therefore pair each short branch with both one-word and multi-word successors. A wrong merge rule shows only when a run nests inside another, and the nested cases are built so that adding, overwriting and taking the maximum each give a different free boundary.

// File: rtl/iaw_pkg.sv
package iaw_pkg;

   typedef enum logic [2:0] {
      IC_PLAIN    = 3'd0,
      IC_DELAYED  = 3'd1,
      IC_REPEAT   = 3'd2,
      IC_BR_SHORT = 3'd3,
      IC_BR_LONG  = 3'd4,
      IC_BITBR    = 3'd5,
      IC_JCC      = 3'd6,
      IC_SWI_TOP  = 3'd7
   } iclass_e;

endpackage

// File: rtl/iaw_span_decode.sv
module iaw_span_decode
   import iaw_pkg::*;
#(
   parameter int SLOT_W     = 2,
   parameter int WORD_W     = 2,
   parameter int LEFT_W     = 4,
   parameter int LOOP_GUARD = 3
) (
   input  logic [2:0]        cls_i,
   input  logic [WORD_W-1:0] words_i,
   input  logic              taken_i,
   input  logic [SLOT_W-1:0] slots_i,
   input  logic              loop_last_i,
   input  logic [LEFT_W-1:0] loop_left_i,
   input  logic              cond_pend_i,
   output logic [SLOT_W-1:0] span_o,
   output logic              arm_cond_o,
   output logic              cond_hit_o,
   output logic              loop_blk_o,
   output logic              swi_o
);

   localparam logic [SLOT_W-1:0] ONE_SPAN = SLOT_W'(1);
   localparam logic [WORD_W-1:0] ONE_WORD = WORD_W'(1);

   iclass_e cls;
   assign cls = iclass_e'(cls_i);

   always_comb begin
      span_o     = '0;
      arm_cond_o = 1'b0;
      swi_o      = 1'b0;
      unique case (cls)
         IC_DELAYED:  span_o = slots_i;
         IC_REPEAT,
         IC_BR_LONG,
         IC_JCC:      span_o = ONE_SPAN;
         IC_BR_SHORT: begin
            span_o     = ONE_SPAN;
            arm_cond_o = 1'b1;
         end
         IC_BITBR: begin
            if (!taken_i) begin
               span_o     = ONE_SPAN;
               arm_cond_o = 1'b1;
            end
         end
         IC_SWI_TOP:  swi_o = 1'b1;
         default:     span_o = '0;
      endcase
   end

   // A short branch decided one instruction ago: a one-word successor
   // extends the run by one more boundary.
   assign cond_hit_o = cond_pend_i && (words_i == ONE_WORD);

   generate
      if (LOOP_GUARD == 0) begin : g_no_loop_guard
         assign loop_blk_o = 1'b0;
      end else begin : g_loop_guard
         localparam logic [LEFT_W-1:0] GUARD = LEFT_W'(LOOP_GUARD);
         assign loop_blk_o = loop_last_i && (loop_left_i != '0)
                             && (loop_left_i <= GUARD);
      end
   endgenerate

endmodule

// File: rtl/iaw_run_counter.sv
module iaw_run_counter #(
   parameter int SLOT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [SLOT_W-1:0] span_i,
   input  logic              arm_cond_i,
   input  logic              swi_i,
   output logic [SLOT_W-1:0] cnt_q,
   output logic              cond_q,
   output logic              swi_q
);

   localparam logic [SLOT_W-1:0] ONE = SLOT_W'(1);

   logic [SLOT_W-1:0] dec_cnt, load_cnt, next_cnt;

   always_comb begin
      dec_cnt  = (cnt_q != '0) ? cnt_q - ONE : '0;
      load_cnt = (span_i != '0) ? span_i - ONE : '0;
      next_cnt = (load_cnt > dec_cnt) ? load_cnt : dec_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         cond_q <= 1'b0;
         swi_q  <= 1'b0;
      end else begin
         swi_q <= issue_valid && swi_i;
         if (issue_valid) begin
            if (swi_i) begin
               cnt_q  <= '0;
               cond_q <= 1'b0;
            end else begin
               cnt_q  <= next_cnt;
               cond_q <= arm_cond_i;
            end
         end
      end
   end

   // R11: a nested protector never shortens the remaining run
   a_r11_no_shrink: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && !swi_i && cnt_q > ONE) |=> (cnt_q >= $past(cnt_q) - ONE));

   // R8: a software interrupt leaves no run behind
   a_r8_swi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && swi_i) |=> (cnt_q == '0 && !cond_q));

endmodule

// File: rtl/iaw_window_ctrl.sv
module iaw_window_ctrl
   import iaw_pkg::*;
#(
   parameter int SLOT_W     = 2,
   parameter int WORD_W     = 2,
   parameter int LEFT_W     = 4,
   parameter int LOOP_GUARD = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic [2:0]        issue_class,
   input  logic [WORD_W-1:0] issue_words,
   input  logic              issue_taken,
   input  logic [SLOT_W-1:0] issue_slots,
   input  logic              issue_loop_last,
   input  logic [LEFT_W-1:0] issue_loop_left,
   input  logic              irq_req,
   output logic              allow_o,
   output logic              irq_take_o,
   output logic              swi_take_o
);

   generate
      if (SLOT_W < 1) begin : g_bad_slot
         $error("SLOT_W must be at least 1");
      end
      if (WORD_W < 1) begin : g_bad_word
         $error("WORD_W must be at least 1");
      end
      if (LOOP_GUARD < 0 || LOOP_GUARD >= (1 << LEFT_W)) begin : g_bad_guard
         $error("LOOP_GUARD must fit in LEFT_W bits");
      end
   endgenerate

   logic [SLOT_W-1:0] span, cnt_q;
   logic              arm_cond, cond_hit, loop_blk, swi, cond_q;
   logic              blocked;

   iaw_span_decode #(
      .SLOT_W(SLOT_W), .WORD_W(WORD_W), .LEFT_W(LEFT_W), .LOOP_GUARD(LOOP_GUARD)
   ) u_decode (
      .cls_i       (issue_class),
      .words_i     (issue_words),
      .taken_i     (issue_taken),
      .slots_i     (issue_slots),
      .loop_last_i (issue_loop_last),
      .loop_left_i (issue_loop_left),
      .cond_pend_i (cond_q),
      .span_o      (span),
      .arm_cond_o  (arm_cond),
      .cond_hit_o  (cond_hit),
      .loop_blk_o  (loop_blk),
      .swi_o       (swi)
   );

   iaw_run_counter #(.SLOT_W(SLOT_W)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_valid (issue_valid),
      .span_i      (span),
      .arm_cond_i  (arm_cond),
      .swi_i       (swi),
      .cnt_q       (cnt_q),
      .cond_q      (cond_q),
      .swi_q       (swi_take_o)
   );

   assign blocked    = (cnt_q != '0) || cond_hit || (span != '0) || loop_blk || swi;
   assign allow_o    = issue_valid && !blocked;
   assign irq_take_o = allow_o && irq_req;

   // R1: an active run refuses every boundary inside it
   a_r1_run_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && cnt_q != '0) |-> !allow_o);

   // R2: a repeat instruction is never separated from its target
   a_r2_repeat_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_class == 3'd2) |-> !allow_o);

   // R6: a taken bit-test branch with no other protection is free
   a_r6_taken_free: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_class == 3'd5 && issue_taken && cnt_q == '0
       && !cond_q && !loop_blk) |-> allow_o);

   // R8: a software interrupt is followed by one exception request
   a_r8_swi_request: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_class == 3'd7) |=> swi_take_o);

   // R8: the exception request only ever follows an issued instruction
   a_r8_swi_origin: assert property (@(posedge clk) disable iff (!rst_n)
      swi_take_o |-> $past(issue_valid));

   // R10: no interrupt is accepted without an issued instruction
   a_r10_take_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |-> (issue_valid && irq_req && cnt_q == '0));

endmodule

// File: tb/tb_iaw_window_ctrl.sv
`timescale 1ns/1ps
module tb_iaw_window_ctrl;

   localparam int SLOT_W = 2;
   localparam int WORD_W = 2;
   localparam int LEFT_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              issue_valid = 1'b0;
   logic [2:0]        issue_class = '0;
   logic [WORD_W-1:0] issue_words = WORD_W'(1);
   logic              issue_taken = 1'b0;
   logic [SLOT_W-1:0] issue_slots = '0;
   logic              issue_loop_last = 1'b0;
   logic [LEFT_W-1:0] issue_loop_left = '0;
   logic              irq_req = 1'b0;
   logic              allow_o, irq_take_o, swi_take_o;

   int checks = 0;
   int errors = 0;

   iaw_window_ctrl #(.SLOT_W(SLOT_W), .WORD_W(WORD_W), .LEFT_W(LEFT_W)) dut (
      .clk, .rst_n, .issue_valid, .issue_class, .issue_words, .issue_taken,
      .issue_slots, .issue_loop_last, .issue_loop_left, .irq_req,
      .allow_o, .irq_take_o, .swi_take_o
   );

   always #4 clk = ~clk;   // 125 MHz

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Issue one instruction, then check the boundary after it.
   task automatic issue(input logic [2:0] cls, input int words, input logic taken,
                        input int slots, input logic last, input int left,
                        input logic irq, input logic exp_allow, input string tag);
      @(negedge clk);
      issue_valid     = 1'b1;
      issue_class     = cls;
      issue_words     = WORD_W'(words);
      issue_taken     = taken;
      issue_slots     = SLOT_W'(slots);
      issue_loop_last = last;
      issue_loop_left = LEFT_W'(left);
      irq_req         = irq;
      #2;
      check({tag, " allow"}, allow_o, exp_allow);
      check({tag, " take"}, irq_take_o, exp_allow && irq);
   endtask

   task automatic plain(input logic exp_allow, input string tag);
      issue(3'd0, 1, 1'b0, 0, 1'b0, 0, 1'b1, exp_allow, tag);
   endtask

   task automatic idle();
      @(negedge clk);
      issue_valid = 1'b0;
      irq_req     = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      issue_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      issue(3'd1, 1, 1'b0, 3, 1'b0, 0, 1'b0, 1'b0, "R12 pre-reset run");
      do_reset();
      #2;
      check("R12 swi after reset", swi_take_o, 1'b0);
      plain(1'b1, "R12 first boundary");
   endtask

   task automatic t_delayed();
      issue(3'd1, 1, 1'b0, 2, 1'b0, 0, 1'b1, 1'b0, "R1 delayed S=2");
      plain(1'b0, "R1 slot1");
      plain(1'b1, "R1 slot2 free");
      issue(3'd1, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b1, "R1 delayed S=0");
      issue(3'd1, 1, 1'b0, 3, 1'b0, 0, 1'b0, 1'b0, "R1 delayed S=3");
      plain(1'b0, "R1 s3 slot1");
      plain(1'b0, "R1 s3 slot2");
      plain(1'b1, "R1 s3 slot3 free");
   endtask

   task automatic t_repeat();
      issue(3'd2, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R2 repeat");
      plain(1'b1, "R2 target free");
   endtask

   task automatic t_short_branch();
      issue(3'd3, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R3 short branch");
      issue(3'd0, 2, 1'b0, 0, 1'b0, 0, 1'b1, 1'b1, "R3 multiword next free");
      issue(3'd3, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R4 short branch");
      plain(1'b0, "R4 one-word next");
      plain(1'b1, "R4 third free");
      issue(3'd3, 1, 1'b1, 0, 1'b0, 0, 1'b1, 1'b0, "R4 taken short branch");
      plain(1'b0, "R4 taken one-word next");
      plain(1'b1, "R4 taken third free");
   endtask

   task automatic t_bit_branch();
      issue(3'd5, 2, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R5 bit branch");
      plain(1'b0, "R5 one-word next");
      plain(1'b1, "R5 third free");
      issue(3'd5, 2, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R5 bit branch mw");
      issue(3'd0, 3, 1'b0, 0, 1'b0, 0, 1'b1, 1'b1, "R5 multiword next free");
      issue(3'd5, 2, 1'b1, 0, 1'b0, 0, 1'b1, 1'b1, "R6 taken bit branch free");
      plain(1'b1, "R6 target free");
   endtask

   task automatic t_long_and_jcc();
      issue(3'd4, 2, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R7 long branch");
      plain(1'b1, "R7 one-word next free");
      issue(3'd6, 2, 1'b1, 0, 1'b0, 0, 1'b1, 1'b0, "R7 jcc");
      plain(1'b1, "R7 jcc next free");
   endtask

   task automatic t_swi();
      issue(3'd1, 1, 1'b0, 3, 1'b0, 0, 1'b1, 1'b0, "R8 run before swi");
      issue(3'd7, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R8 swi");
      idle();
      #2;
      check("R8 swi request", swi_take_o, 1'b1);
      idle();
      #2;
      check("R8 swi single pulse", swi_take_o, 1'b0);
      plain(1'b1, "R8 run cleared");
   endtask

   task automatic t_loop();
      issue(3'd0, 1, 1'b0, 0, 1'b1, 4, 1'b1, 1'b1, "R9 left=4 free");
      issue(3'd0, 1, 1'b0, 0, 1'b1, 3, 1'b1, 1'b0, "R9 left=3");
      issue(3'd0, 1, 1'b0, 0, 1'b1, 2, 1'b1, 1'b0, "R9 left=2");
      issue(3'd0, 1, 1'b0, 0, 1'b1, 1, 1'b1, 1'b0, "R9 left=1");
      issue(3'd0, 1, 1'b0, 0, 1'b1, 0, 1'b1, 1'b1, "R9 left=0 free");
      issue(3'd0, 1, 1'b0, 0, 1'b0, 2, 1'b1, 1'b1, "R9 not last free");
   endtask

   task automatic t_deferral();
      issue(3'd1, 1, 1'b0, 2, 1'b0, 0, 1'b1, 1'b0, "R10 request held");
      plain(1'b0, "R10 still deferred");
      plain(1'b1, "R10 taken at end");
      issue(3'd0, 1, 1'b0, 0, 1'b0, 0, 1'b0, 1'b1, "R10 no request");
   endtask

   task automatic t_nesting();
      // larger nested span wins; accumulate would block one more
      issue(3'd1, 1, 1'b0, 2, 1'b0, 0, 1'b1, 1'b0, "R11 outer S=2");
      issue(3'd1, 1, 1'b0, 3, 1'b0, 0, 1'b1, 1'b0, "R11 inner S=3");
      plain(1'b0, "R11 inner slot1");
      plain(1'b0, "R11 inner slot2");
      plain(1'b1, "R11 inner slot3 free");
      // smaller nested span keeps the remaining run; overwrite would free early
      issue(3'd1, 1, 1'b0, 3, 1'b0, 0, 1'b1, 1'b0, "R11 outer S=3");
      issue(3'd2, 1, 1'b0, 0, 1'b0, 0, 1'b1, 1'b0, "R11 repeat inside");
      plain(1'b0, "R11 remaining kept");
      plain(1'b1, "R11 run end free");
   endtask

   initial begin
      do_reset();
      #2;
      check("R12 swi idle at reset", swi_take_o, 1'b0);
      plain(1'b1, "R12 first boundary");
      t_delayed();
      t_repeat();
      t_short_branch();
      t_bit_branch();
      t_long_and_jcc();
      t_swi();
      t_loop();
      t_deferral();
      t_nesting();
      t_reset();
      idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule